// File: doc/BRIEF.md
# Packet Page Allocator With Queues

This block handles buffer memory for a small network controller. The memory is split into a few fixed packet pages, four by default. A bitmap records which pages are in use. Three queues carry page numbers. The transmit queue holds pages waiting to go out. The completion queue holds pages that were sent but not yet released. The receive queue holds pages that contain incoming frames. One sticky interrupt status byte and one mask byte drive a single interrupt line.

The host controls the block with command bytes. Bits 7:5 of each byte select the operation. Commands allocate pages, release them, pop a queue or push a page, and a page-select input names the page that a command acts on. A receive port asks for a page for each incoming frame and is answered in the same cycle. A transmit handshake presents the head of the transmit queue and retires it when the link reports it sent. Each command, acknowledge or event completes in one clock, so a new command can be accepted every cycle.

When an allocation finds no free page, it stays pending. It completes as soon as any page is released.

Top module: `pkt_page_mmu`

## Requirements
- R1: After reset the page bitmap is 0, the allocation result is 0, the interrupt status is 0x04, the mask is 0, both the receive head and the completion head read 0x80, and irq is low.
- R2: Command code 1 (byte 0x20) first sets the result to 0x80 and clears status bit 3 (0x08). It then takes the lowest-numbered free page, sets that page's bitmap bit, writes the page number to the result and sets bit 3. If every page is in use, the result stays 0x80 and bit 3 stays clear.
- R3: Any release (code 5, byte 0xA0; code 4, byte 0x80; or auto-release) made while the result reads 0x80 retries the allocation in the same cycle and sets bit 3 when the retry succeeds.
- R4: A receive request with no command in the same cycle is granted if a page is free. The grant gives the lowest free page, marks it used, appends it to the receive queue and sets status bit 0 (0x01). When no page is free the request is refused.
- R5: Code 3 (byte 0x60) pops the receive queue in arrival order. Bit 0 stays set while entries remain and is cleared when the queue empties. A pop on an empty queue leaves the queue and the bitmap unchanged.
- R6: Code 4 (byte 0x80) frees the page at the head of the receive queue and then pops that queue.
- R7: Code 6 (byte 0xC0) appends page_sel to the transmit queue, and a push to a full queue is dropped. The queue head is presented on tx_valid/tx_page in order, and only while tx_enable is high.
- R8: When a presented page is reported sent, it is freed if auto_release is high. Otherwise it is appended to the completion queue, but only if that queue holds fewer than four entries.
- R9: Status bit 2 (0x04) is forced set whenever the transmit queue is empty. Status bit 1 (0x02) is forced set whenever the completion queue is not empty. An acknowledge cannot clear either bit while its condition holds.
- R10: An acknowledge clears only those written bits that fall inside 0xD6 (bits 7, 6, 4, 2, 1). If the written value includes bit 1, the head of the completion queue is also popped.
- R11: irq is high exactly when the status and the mask share a set bit.
- R12: Code 2 (byte 0x40) clears the bitmap, all three queues and the allocation result. Code 7 (byte 0xE0) clears only the transmit and completion queues. Code 0 changes nothing.
- R13: A receive request made in the same cycle as a command is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command byte is present this cycle |
| cmd_byte | input | 8 | Command byte; bits 7:5 select the operation |
| page_sel | input | PW | Page used by the release and push commands |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_bits | input | 8 | Status bits to clear |
| mask_valid | input | 1 | Mask write strobe |
| mask_bits | input | 8 | New interrupt mask |
| tx_enable | input | 1 | Allows the transmit queue head to be presented |
| auto_release | input | 1 | Frees sent pages instead of queueing them for completion |
| rx_req | input | 1 | Receive side asks for a page |
| rx_ack | output | 1 | The receive request is granted this cycle |
| rx_page | output | PW | Page granted to the receive side |
| tx_valid | output | 1 | A page is offered for transmission |
| tx_page | output | PW | Offered page |
| tx_sent | input | 1 | The offered page has been sent |
| alloc_result | output | 8 | Last allocation result; 0x80 means failed or pending |
| done_head | output | 8 | Head of the completion queue, or 0x80 when it is empty |
| rx_head | output | 8 | Head of the receive queue, or 0x80 when it is empty |
| int_status | output | 8 | Interrupt status |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt line |
| page_map | output | PAGES | Page-in-use bitmap |

## Verification
The bench fills every page through both the command path and the receive path, then checks that each grant takes the lowest free page. A design that scanned from the wrong end would hand out pages in the wrong order. A design that lost a pending allocation would leave the result at 0x80 after a release, instead of handing over the page just freed. The bench fills the transmit queue and the completion queue to their limits. A design without a proper full guard would either accept a fifth page or overwrite an older completion entry, and the pop sequence would then show it. Acknowledges are written while the queue conditions hold and while they do not. A design that did not re-derive the transmit-empty and completion bits would let software clear them while their conditions still held.

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu #(
  parameter int PAGES = 4,
  parameter int PW = (PAGES > 1) ? $clog2(PAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_byte,
  input  logic [PW-1:0]    page_sel,
  input  logic             ack_valid,
  input  logic [7:0]       ack_bits,
  input  logic             mask_valid,
  input  logic [7:0]       mask_bits,
  input  logic             tx_enable,
  input  logic             auto_release,
  input  logic             rx_req,
  output logic             rx_ack,
  output logic [PW-1:0]    rx_page,
  output logic             tx_valid,
  output logic [PW-1:0]    tx_page,
  input  logic             tx_sent,
  output logic [7:0]       alloc_result,
  output logic [7:0]       done_head,
  output logic [7:0]       rx_head,
  output logic [7:0]       int_status,
  output logic [7:0]       int_mask,
  output logic             irq,
  output logic [PAGES-1:0] page_map
);
  localparam int CW = $clog2(PAGES + 1);
  localparam logic [7:0] NONE = 8'h80;
  localparam logic [7:0] ACK_OK = 8'hD6;
  localparam logic [CW-1:0] FULL = CW'(PAGES);

  logic [PAGES-1:0] map_q, map_d;
  logic [PW-1:0] tq_q [PAGES], tq_d [PAGES];
  logic [PW-1:0] dq_q [PAGES], dq_d [PAGES];
  logic [PW-1:0] rq_q [PAGES], rq_d [PAGES];
  logic [CW-1:0] tn_q, tn_d, dn_q, dn_d, rn_q, rn_d;
  logic [7:0] res_q, res_d, st_q, st_d, mk_q, mk_d;

  function automatic logic [7:0] lowest_free(input logic [PAGES-1:0] m);
    logic [7:0] r;
    r = NONE;
    for (int i = PAGES - 1; i >= 0; i--)
      if (!m[i]) r = 8'(i);
    return r;
  endfunction

  logic [7:0] rx_pick;
  assign rx_pick  = lowest_free(map_q);
  assign rx_ack   = rx_req && !cmd_valid && (rx_pick != NONE);
  assign rx_page  = rx_pick[PW-1:0];
  assign tx_valid = tx_enable && (tn_q != '0);
  assign tx_page  = tq_q[0];

  always_comb begin
    logic [7:0] a;
    logic [PW-1:0] pg;
    logic rel;
    map_d = map_q; tq_d = tq_q; dq_d = dq_q; rq_d = rq_q;
    tn_d = tn_q; dn_d = dn_q; rn_d = rn_q;
    res_d = res_q; st_d = st_q; mk_d = mk_q;
    a = NONE; pg = '0; rel = 1'b0;

    if (rx_ack) begin
      map_d[rx_page] = 1'b1;
      rq_d[rn_d[PW-1:0]] = rx_page;
      rn_d = rn_d + 1'b1;
      st_d[0] = 1'b1;
    end

    if (tx_valid && tx_sent) begin
      pg = tq_d[0];
      for (int i = 0; i < PAGES - 1; i++) tq_d[i] = tq_d[i+1];
      tn_d = tn_d - 1'b1;
      if (auto_release) begin
        map_d[pg] = 1'b0;
        if (res_d == NONE) begin
          a = lowest_free(map_d);
          if (a != NONE) begin
            res_d = a; map_d[a[PW-1:0]] = 1'b1; st_d[3] = 1'b1;
          end
        end
      end else if (dn_d < FULL) begin
        dq_d[dn_d[PW-1:0]] = pg;
        dn_d = dn_d + 1'b1;
      end
    end

    if (cmd_valid) begin
      case (cmd_byte[7:5])
        3'd1: begin
          res_d = NONE; st_d[3] = 1'b0;
          a = lowest_free(map_d);
          if (a != NONE) begin
            res_d = a; map_d[a[PW-1:0]] = 1'b1; st_d[3] = 1'b1;
          end
        end
        3'd2: begin
          map_d = '0; tn_d = '0; dn_d = '0; rn_d = '0; res_d = '0;
        end
        3'd3, 3'd4: begin
          if (rn_d != '0) begin
            if (cmd_byte[7]) begin rel = 1'b1; pg = rq_d[0]; end
            for (int i = 0; i < PAGES - 1; i++) rq_d[i] = rq_d[i+1];
            rn_d = rn_d - 1'b1;
          end
          st_d[0] = (rn_d != '0);
        end
        3'd5: begin rel = 1'b1; pg = page_sel; end
        3'd6: begin
          if (tn_d < FULL) begin
            tq_d[tn_d[PW-1:0]] = page_sel;
            tn_d = tn_d + 1'b1;
          end
        end
        3'd7: begin tn_d = '0; dn_d = '0; end
        default: ;
      endcase
      if (rel) begin
        map_d[pg] = 1'b0;
        if (res_d == NONE) begin
          a = lowest_free(map_d);
          if (a != NONE) begin
            res_d = a; map_d[a[PW-1:0]] = 1'b1; st_d[3] = 1'b1;
          end
        end
      end
    end

    if (ack_valid) begin
      st_d = st_d & ~(ack_bits & ACK_OK);
      if (ack_bits[1] && dn_d != '0) begin
        for (int i = 0; i < PAGES - 1; i++) dq_d[i] = dq_d[i+1];
        dn_d = dn_d - 1'b1;
      end
    end

    if (tn_d == '0) st_d[2] = 1'b1;
    if (dn_d != '0) st_d[1] = 1'b1;
    if (mask_valid) mk_d = mask_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= '0; tn_q <= '0; dn_q <= '0; rn_q <= '0;
      res_q <= '0; st_q <= 8'h04; mk_q <= '0;
      for (int i = 0; i < PAGES; i++) begin
        tq_q[i] <= '0; dq_q[i] <= '0; rq_q[i] <= '0;
      end
    end else begin
      map_q <= map_d; tq_q <= tq_d; dq_q <= dq_d; rq_q <= rq_d;
      tn_q <= tn_d; dn_q <= dn_d; rn_q <= rn_d;
      res_q <= res_d; st_q <= st_d; mk_q <= mk_d;
    end
  end

  assign page_map     = map_q;
  assign alloc_result = res_q;
  assign int_status   = st_q;
  assign int_mask     = mk_q;
  assign irq          = |(st_q & mk_q);
  assign done_head    = (dn_q == '0) ? NONE : 8'(dq_q[0]);
  assign rx_head      = (rn_q == '0) ? NONE : 8'(rq_q[0]);

  assert_full_alloc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_byte[7:5] == 3'd1 && (&page_map) && !(tx_valid && tx_sent && auto_release))
    |=> alloc_result == NONE);
  assert_grant_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |=> page_map[$past(rx_page)]);
  assert_rx_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_head != NONE && !cmd_valid) |=> rx_head == $past(rx_head));
  assert_tx_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_sent && !cmd_valid && tx_enable) |=> $stable(tx_page));
  assert_tx_empty_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tn_q == '0) |-> int_status[2]);
  assert_done_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_head != NONE) |-> int_status[1]);
endmodule

// File: tb/pkt_page_mmu_tb_top.sv
module pkt_page_mmu_tb_top;
  localparam int PAGES = 4;
  localparam int PW = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, ack_valid = 0, mask_valid = 0, tx_enable = 0, auto_release = 0;
  logic rx_req = 0, tx_sent = 0;
  logic [7:0] cmd_byte = 0, ack_bits = 0, mask_bits = 0;
  logic [PW-1:0] page_sel = 0;
  logic rx_ack, tx_valid, irq;
  logic [PW-1:0] rx_page, tx_page;
  logic [7:0] alloc_result, done_head, rx_head, int_status, int_mask;
  logic [PAGES-1:0] page_map;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pkt_page_mmu #(.PAGES(PAGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .page_sel(page_sel), .ack_valid(ack_valid), .ack_bits(ack_bits),
    .mask_valid(mask_valid), .mask_bits(mask_bits), .tx_enable(tx_enable),
    .auto_release(auto_release), .rx_req(rx_req), .rx_ack(rx_ack), .rx_page(rx_page),
    .tx_valid(tx_valid), .tx_page(tx_page), .tx_sent(tx_sent),
    .alloc_result(alloc_result), .done_head(done_head), .rx_head(rx_head),
    .int_status(int_status), .int_mask(int_mask), .irq(irq), .page_map(page_map));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] b);
    cmd_byte = b; cmd_valid = 1; @(negedge clk); cmd_valid = 0;
  endtask
  task automatic ack(input logic [7:0] b);
    ack_bits = b; ack_valid = 1; @(negedge clk); ack_valid = 0;
  endtask
  task automatic set_mask(input logic [7:0] b);
    mask_bits = b; mask_valid = 1; @(negedge clk); mask_valid = 0;
  endtask
  task automatic send();
    tx_sent = 1; @(negedge clk); tx_sent = 0;
  endtask
  task automatic rx_try(output logic g, output logic [PW-1:0] p);
    rx_req = 1; #1; g = rx_ack; p = rx_page; @(negedge clk); rx_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic g;
    logic [PW-1:0] p;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 map", page_map, 0);
    chk("R1 result", alloc_result, 0);
    chk("R1 status", int_status, 8'h04);
    chk("R1 mask", int_mask, 0);
    chk("R1 rx head", rx_head, 8'h80);
    chk("R1 done head", done_head, 8'h80);
    chk("R1 irq", irq, 0);

    for (int i = 0; i < PAGES; i++) begin
      cmd(8'h20);
      chk("R2 alloc page", alloc_result, i);
      chk("R2 map fill", page_map, (1 << (i + 1)) - 1);
      chk("R2 bit3", int_status[3], 1);
    end
    ack(8'h08);
    chk("R10 bit3 outside ack set", int_status[3], 1);
    ack(8'hFF);
    chk("R9 R10 status after ack all", int_status, 8'h0C);
    cmd(8'h20);
    chk("R2 full result", alloc_result, 8'h80);
    chk("R2 full bit3", int_status[3], 0);
    page_sel = 2;
    cmd(8'hA0);
    chk("R3 retry result", alloc_result, 2);
    chk("R3 retry map", page_map, 4'hF);
    chk("R3 retry bit3", int_status[3], 1);

    cmd(8'h40);
    chk("R12 reset map", page_map, 0);
    chk("R12 reset result", alloc_result, 0);
    for (int i = 0; i < 3; i++) begin
      rx_try(g, p);
      chk("R4 grant", g, 1);
      chk("R4 grant page", p, i);
    end
    rx_req = 1; cmd_byte = 8'h00; cmd_valid = 1; #1;
    chk("R13 refused with command", rx_ack, 0);
    @(negedge clk); rx_req = 0; cmd_valid = 0;
    chk("R12 noop map", page_map, 4'b0111);
    chk("R4 rx bit", int_status[0], 1);
    chk("R5 rx head", rx_head, 0);
    cmd(8'h60);
    chk("R5 pop order", rx_head, 1);
    chk("R5 bit kept", int_status[0], 1);
    cmd(8'h80);
    chk("R6 release head", page_map, 4'b0101);
    chk("R6 next head", rx_head, 2);
    cmd(8'h60);
    chk("R5 empty head", rx_head, 8'h80);
    chk("R5 bit cleared", int_status[0], 0);
    cmd(8'h60);
    chk("R5 empty pop head", rx_head, 8'h80);
    chk("R5 empty pop map", page_map, 4'b0101);
    rx_try(g, p);
    chk("R4 lowest free", p, 1);
    rx_try(g, p);
    chk("R4 lowest free next", p, 3);
    rx_try(g, p);
    chk("R4 refused full", g, 0);
    chk("R4 full map", page_map, 4'hF);

    cmd(8'h40);
    cmd(8'h20); cmd(8'h20);
    page_sel = 0; cmd(8'hC0);
    page_sel = 1; cmd(8'hC0);
    chk("R7 gated", tx_valid, 0);
    ack(8'h04);
    chk("R9 tx empty clears", int_status[2], 0);
    tx_enable = 1; #1;
    chk("R7 valid", tx_valid, 1);
    chk("R7 first", tx_page, 0);
    @(negedge clk);
    send();
    chk("R7 second", tx_page, 1);
    chk("R8 done head", done_head, 0);
    chk("R9 done bit", int_status[1], 1);
    send();
    chk("R7 drained", tx_valid, 0);
    chk("R9 tx empty set", int_status[2], 1);
    chk("R8 map kept", page_map, 4'b0011);
    ack(8'h02);
    chk("R10 pop done", done_head, 1);
    chk("R9 done bit kept", int_status[1], 1);
    ack(8'h02);
    chk("R10 done empty", done_head, 8'h80);
    chk("R10 done bit cleared", int_status[1], 0);
    auto_release = 1;
    page_sel = 1; cmd(8'hC0);
    send();
    chk("R8 auto release map", page_map, 4'b0001);
    chk("R8 auto no done", done_head, 8'h80);

    auto_release = 0; tx_enable = 0;
    page_sel = 0;
    for (int i = 0; i < 4; i++) cmd(8'hC0);
    page_sel = 1; cmd(8'hC0);
    tx_enable = 1;
    for (int i = 0; i < 4; i++) begin
      #1; chk("R7 full queue entry", tx_page, 0);
      @(negedge clk); send();
    end
    chk("R7 fifth dropped", tx_valid, 0);
    page_sel = 1; cmd(8'hC0);
    send();
    for (int i = 0; i < 3; i++) ack(8'h02);
    chk("R8 done entry kept", done_head, 0);
    ack(8'h02);
    chk("R8 full done dropped", done_head, 8'h80);
    tx_enable = 0;
    page_sel = 0; cmd(8'hC0); cmd(8'hE0);
    tx_enable = 1; #1;
    chk("R12 tx cleared", tx_valid, 0);
    @(negedge clk); tx_enable = 0;
    chk("R12 map unchanged", page_map, 4'b0001);

    set_mask(8'h04);
    chk("R11 irq high", irq, 1);
    set_mask(8'h20);
    chk("R11 irq low", irq, 0);

    cmd(8'h40);
    for (int i = 0; i < 4; i++) rx_try(g, p);
    cmd(8'h20);
    chk("R3 pending", alloc_result, 8'h80);
    cmd(8'h80);
    chk("R3 retry on rx release", alloc_result, 0);
    chk("R3 map full again", page_map, 4'hF);
    chk("R6 head advanced", rx_head, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule